// File: doc/BRIEF.md
# Bounded Reversed-Order Vector Element File

This block is a file of 64 vector registers, each 128 bits wide, that is read and written one element at a time. An element is 8, 16, 32 or 64 bits wide, chosen per access by a 2-bit width code. A 128-bit register always holds a fixed number of elements: 16 bytes, 8 halfwords, 4 words or 2 doublewords.

Element numbering runs opposite to the storage layout. Logical element 0 sits in the most-significant lane of the register, and the last element sits in the least-significant lane. An index that is too large for the chosen width never reaches into a neighbouring register. Instead the access is flagged as an error, the read returns zero and any write is dropped.

The register number, element index and width code are shared by the read path and the write path. The element is read combinationally and returned zero-extended. A write lands on the rising clock edge and changes only the bytes of the addressed element.

Top module: `vrf_elem_file`

## Requirements
- R1: While `rst_n` is low, every register is cleared asynchronously. After reset, every element of every register reads as zero.
- R2: The width code selects both the element size and the element count. 2'b00 is 64 bits with 2 elements, 2'b01 is 32 bits with 4, 2'b10 is 16 bits with 8, and 2'b11 is 8 bits with 16. An index below the count is in range. An index equal to or above the count raises `range_err` in the same cycle.
- R3: With N elements of B bytes each, logical element i occupies the bytes starting at byte (N-1-i)*B, counting byte 0 as bits 7:0. Element 0 therefore always contains bit 127.
- R4: A read is combinational. When the index is in range, `rd_data` holds the addressed element in its low bits, and all bits above the element width are zero.
- R5: A write with `wr_en` high and an in-range index updates the addressed register at the rising clock edge. The element's bytes take the low bytes of `wr_data`, and every other byte of that register keeps its value.
- R6: When `range_err` is high, `rd_data` is zero.
- R7: A write with an out-of-range index changes no register at all. This includes the addressed register and the register numbered after it.
- R8: A write changes only the register selected by `reg_sel`.
- R9: While `wr_en` is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| reg_sel | input | 6 | Register number for the read and the write |
| elem_idx | input | 4 | Logical element index |
| width_code | input | 2 | Element width: 00=64, 01=32, 10=16, 11=8 bits |
| wr_en | input | 1 | Write enable |
| wr_data | input | 64 | Write element, right-aligned |
| rd_data | output | 64 | Read element, zero-extended |
| range_err | output | 1 | Index is at or beyond the element count for the width |

## Verification
The bench first writes a whole doubleword and then reads it back at every narrower width. This separates a correct reversed lane order from a little-endian order or an off-by-one slot. Sweeping each width at its last legal index and at the first illegal one pins down the per-width bound. Out-of-range writes are aimed at a register whose neighbour holds known data, which would expose any spill across registers. A long random mix of widths, indices, registers and enables, concentrated on a few registers so that reads hit earlier writes, is compared with a byte-level model. This catches partial-byte corruption and writes to the wrong register.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int REG_BYTES = 16;
  localparam int REG_BITS  = REG_BYTES * 8;
  localparam int ELEM_MAXB = 8;
  localparam int ELEM_BITS = ELEM_MAXB * 8;
  localparam int OFF_W     = $clog2(REG_BYTES);
  localparam int IDX_W     = $clog2(REG_BYTES);

  typedef enum logic [1:0] {
    WC_64 = 2'b00,
    WC_32 = 2'b01,
    WC_16 = 2'b10,
    WC_8  = 2'b11
  } width_e;

  // elements per register for a width code
  function automatic logic [IDX_W:0] elem_count(input width_e wc);
    case (wc)
      WC_64:   elem_count = (IDX_W+1)'(2);
      WC_32:   elem_count = (IDX_W+1)'(4);
      WC_16:   elem_count = (IDX_W+1)'(8);
      default: elem_count = (IDX_W+1)'(16);
    endcase
  endfunction

  // log2 of the bytes per element
  function automatic logic [1:0] elem_lgb(input width_e wc);
    elem_lgb = 2'(3) - 2'(wc);
  endfunction
endpackage

// File: rtl/vrf_lane_map.sv
module vrf_lane_map
  import vrf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     elem_idx,
  input  logic [1:0]           width_code,
  output logic [OFF_W-1:0]     byte_off,
  output logic [ELEM_MAXB-1:0] elem_bytes,
  output logic [REG_BYTES-1:0] byte_mask,
  output logic                 range_err
);
  width_e         wc;
  logic [IDX_W:0] count;
  logic [IDX_W:0] slot;
  logic [1:0]     lgb;

  always_comb begin
    wc         = width_e'(width_code);
    count      = elem_count(wc);
    lgb        = elem_lgb(wc);
    range_err  = ({1'b0, elem_idx} >= count);
    slot       = count - (IDX_W+1)'(1) - {1'b0, elem_idx};
    byte_off   = OFF_W'(slot << lgb);
    elem_bytes = ELEM_MAXB'((9'd1 << (4'd1 << lgb)) - 9'd1);
    byte_mask  = range_err ? '0
               : (REG_BYTES'(elem_bytes) << byte_off);
  end

  // R6
  mask_zero_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> (byte_mask == '0));

  // R5
  mask_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !range_err |-> ($countones(byte_mask) == (1 << (3 - int'(width_code)))));
endmodule

// File: rtl/vrf_elem_extract.sv
module vrf_elem_extract
  import vrf_pkg::*;
(
  input  logic [REG_BITS-1:0]  word,
  input  logic [OFF_W-1:0]     byte_off,
  input  logic [ELEM_MAXB-1:0] elem_bytes,
  input  logic                 range_err,
  output logic [ELEM_BITS-1:0] elem
);
  logic [REG_BITS-1:0] shifted;

  always_comb shifted = word >> {byte_off, 3'b000};

  for (genvar b = 0; b < ELEM_MAXB; b++) begin : g_byte
    always_comb
      elem[8*b +: 8] = (range_err || !elem_bytes[b]) ? 8'h00 : shifted[8*b +: 8];
  end
endmodule

// File: rtl/vrf_byte_merge.sv
module vrf_byte_merge
  import vrf_pkg::*;
(
  input  logic [REG_BITS-1:0]  old_word,
  input  logic [REG_BITS-1:0]  new_bytes,
  input  logic [REG_BYTES-1:0] byte_mask,
  output logic [REG_BITS-1:0]  merged
);
  for (genvar b = 0; b < REG_BYTES; b++) begin : g_lane
    always_comb
      merged[8*b +: 8] = byte_mask[b] ? new_bytes[8*b +: 8] : old_word[8*b +: 8];
  end
endmodule

// File: rtl/vrf_elem_file.sv
module vrf_elem_file
  import vrf_pkg::*;
#(
  parameter int NUM_REGS = 64,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     reg_sel,
  input  logic [IDX_W-1:0]     elem_idx,
  input  logic [1:0]           width_code,
  input  logic                 wr_en,
  input  logic [ELEM_BITS-1:0] wr_data,
  output logic [ELEM_BITS-1:0] rd_data,
  output logic                 range_err
);
  logic [NUM_REGS-1:0][REG_BITS-1:0] file_q;
  logic [NUM_REGS-1:0]               reg_en;
  logic [OFF_W-1:0]                  byte_off;
  logic [ELEM_MAXB-1:0]              elem_bytes;
  logic [REG_BYTES-1:0]              byte_mask;
  logic [REG_BITS-1:0]               sel_word;
  logic [REG_BITS-1:0]               aligned;
  logic [REG_BITS-1:0]               merged;
  logic                              wr_go;

  vrf_lane_map u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .elem_idx   (elem_idx),
    .width_code (width_code),
    .byte_off   (byte_off),
    .elem_bytes (elem_bytes),
    .byte_mask  (byte_mask),
    .range_err  (range_err)
  );

  always_comb begin
    sel_word = file_q[reg_sel];
    aligned  = {{(REG_BITS-ELEM_BITS){1'b0}}, wr_data} << {byte_off, 3'b000};
    wr_go    = wr_en && !range_err;
  end

  vrf_elem_extract u_ext (
    .word       (sel_word),
    .byte_off   (byte_off),
    .elem_bytes (elem_bytes),
    .range_err  (range_err),
    .elem       (rd_data)
  );

  vrf_byte_merge u_merge (
    .old_word  (sel_word),
    .new_bytes (aligned),
    .byte_mask (byte_mask),
    .merged    (merged)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_comb reg_en[g] = wr_go && (reg_sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         file_q[g] <= '0;
      else if (reg_en[g]) file_q[g] <= merged;
    end
  end

  // R7
  no_spill_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && range_err) |=> $stable(file_q));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(file_q));

  // R6
  rd_zero_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> (rd_data == '0));

  // R4
  rd_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (width_code != 2'b00) |-> ((rd_data >> (8 << (3 - int'(width_code)))) == '0));

  // R8
  one_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_en));
endmodule

// File: tb/test_vrf_elem_file.sv
module test_vrf_elem_file;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  reg_sel;
  logic [3:0]  elem_idx;
  logic [1:0]  width_code;
  logic        wr_en;
  logic [63:0] wr_data;
  logic [63:0] rd_data;
  logic        range_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [127:0] mdl [64];

  always #4 clk = ~clk;

  vrf_elem_file i_vrf_elem_file (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .elem_idx(elem_idx),
    .width_code(width_code), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .range_err(range_err)
  );

  function automatic int n_of(input logic [1:0] wc);
    return 2 << wc;
  endfunction
  function automatic int nb_of(input logic [1:0] wc);
    return 8 >> wc;
  endfunction
  function automatic logic err_of(input logic [3:0] idx, input logic [1:0] wc);
    return int'(idx) >= n_of(wc);
  endfunction
  function automatic logic [63:0] exp_rd(input logic [5:0] r, input logic [3:0] idx,
                                         input logic [1:0] wc);
    logic [63:0] v = '0;
    int off;
    if (err_of(idx, wc)) return '0;
    off = (n_of(wc) - 1 - int'(idx)) * nb_of(wc);
    for (int b = 0; b < nb_of(wc); b++) v[8*b +: 8] = mdl[r][8*(off+b) +: 8];
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one access; checks the combinational read, then applies the write at the edge
  task automatic access(input string req, input logic [5:0] r, input logic [3:0] idx,
                        input logic [1:0] wc, input logic we, input logic [63:0] d);
    int off;
    @(negedge clk);
    reg_sel = r; elem_idx = idx; width_code = wc; wr_en = we; wr_data = d;
    #1;
    chk(req, {63'b0, range_err}, {63'b0, err_of(idx, wc)});
    chk(req, rd_data, exp_rd(r, idx, wc));
    @(posedge clk);
    if (we && !err_of(idx, wc)) begin
      off = (n_of(wc) - 1 - int'(idx)) * nb_of(wc);
      for (int b = 0; b < nb_of(wc); b++) mdl[r][8*(off+b) +: 8] = d[8*b +: 8];
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    rst_n = 1'b0; reg_sel = '0; elem_idx = '0; width_code = '0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    access("R1", 6'd0, 4'd0, 2'b00, 1'b0, '0);
    access("R1", 6'd63, 4'd1, 2'b00, 1'b0, '0);
    access("R1", 6'd17, 4'd15, 2'b11, 1'b0, '0);

    // R2: bound per width, last legal and first illegal index
    for (int w = 0; w < 4; w++) begin
      access("R2", 6'd1, 4'(n_of(2'(w)) - 1), 2'(w), 1'b0, '0);
      if (n_of(2'(w)) < 16) access("R2", 6'd1, 4'(n_of(2'(w))), 2'(w), 1'b0, '0);
    end

    // R3: element 0 holds the top lane
    access("R5", 6'd5, 4'd0, 2'b00, 1'b1, 64'h0123_4567_89ab_cdef);
    access("R5", 6'd5, 4'd1, 2'b00, 1'b1, 64'hfedc_ba98_7654_3210);
    @(negedge clk); reg_sel = 6'd5; elem_idx = 4'd0; width_code = 2'b11; wr_en = 1'b0; #1;
    chk("R3", rd_data, 64'h01);
    elem_idx = 4'd15; #1;
    chk("R3", rd_data, 64'h10);
    elem_idx = 4'd1; width_code = 2'b01; #1;
    chk("R3", rd_data, 64'h89ab_cdef);
    access("R3", 6'd5, 4'd3, 2'b10, 1'b0, '0);

    // R5: narrow write keeps neighbour bytes
    access("R5", 6'd5, 4'd6, 2'b11, 1'b1, 64'hffff_ffff_ffff_ff5a);
    access("R5", 6'd5, 4'd0, 2'b00, 1'b0, '0);
    access("R5", 6'd5, 4'd1, 2'b00, 1'b0, '0);

    // R7: out-of-range writes must not spill to reg 6 or change reg 5
    access("R6", 6'd5, 4'd2, 2'b00, 1'b1, 64'hdead_beef_dead_beef);
    access("R6", 6'd5, 4'd4, 2'b01, 1'b1, 64'hdead_beef_dead_beef);
    access("R7", 6'd6, 4'd0, 2'b00, 1'b0, '0);
    access("R7", 6'd6, 4'd1, 2'b00, 1'b0, '0);
    access("R7", 6'd5, 4'd0, 2'b00, 1'b0, '0);
    access("R7", 6'd5, 4'd1, 2'b00, 1'b0, '0);

    // R9: wr_en low leaves data alone
    access("R9", 6'd5, 4'd0, 2'b00, 1'b0, 64'h1111_2222_3333_4444);
    access("R9", 6'd5, 4'd0, 2'b00, 1'b0, '0);

    // R8: write to reg 7 leaves reg 5 intact
    access("R8", 6'd7, 4'd1, 2'b00, 1'b1, 64'haaaa_bbbb_cccc_dddd);
    access("R8", 6'd5, 4'd1, 2'b00, 1'b0, '0);
    access("R8", 6'd7, 4'd1, 2'b00, 1'b0, '0);

    // random mix against the model (R4, R5, R6, R8)
    for (int k = 0; k < 3000; k++) begin
      logic [5:0] r;
      logic [3:0] idx;
      logic [1:0] wc;
      r   = ($urandom % 4 == 0) ? 6'($urandom) : 6'(4 + $urandom % 4);
      wc  = 2'($urandom);
      idx = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % n_of(wc));
      access(err_of(idx, wc) ? "R6" : "R4", r, idx, wc, 1'($urandom), {$urandom, $urandom});
    end

    finish_run();
  end
endmodule